// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. Every control, address and write-data input is captured on the rising clock edge. Reads pass through two register stages: an address stage and an output register. Writes commit at the edge that captures them. Each byte lane can be masked on its own, and a global write forces a write of the whole word.

Accesses come in bursts of four words. A burst begins when one of two start strobes is asserted, the processor start or the controller start. Each later word is reached by asserting the advance input. A 2-bit counter steps the low address bits in either linear or interleaved order.

Three chip selects must all be active for a start to be accepted. A sleep input freezes the block against new activity. An output enable gates the read-valid and read-data outputs without waiting for a clock edge.

Top module: `burst_sram`

## Requirements
- R1: All inputs are sampled at the rising edge. A read presented before edge k is captured at edge k, and its word appears on `rdata` with `rvalid` high after edge k+1.
- R2: When `all_wr_n` is high and `lane_wr_en_n` is low, a write touches only the lanes i with `lane_wr_n[i]` low, where lane i is bits 8i+7:8i. When `lane_wr_en_n` is high, `lane_wr_n` has no effect, and an access with no write lane selected is a read.
- R3: A low `all_wr_n` writes all lanes, whatever the values of `lane_wr_en_n` and `lane_wr_n`.
- R4: A write is committed at the edge that captures it, so a read presented in the next cycle returns the new word. A read whose output register loads at the same edge as a write to that address returns the old word.
- R5: Either start strobe begins a burst at `addr`. A processor start is always a read and ignores the write controls. A controller start reads or writes according to the write controls. When both strobes are low, the processor start wins.
- R6: With no start strobe and a burst active, a low `advance_n` steps a 2-bit counter and accesses the next word, reading or writing according to the write controls. With `linear_order`=1 the low two address bits are (base+n) mod 4. With `linear_order`=0 they are base XOR n. The upper bits stay fixed, and the sequence wraps after four words.
- R7: A start is accepted only when `sel_n`=0, `sel_hi`=1 and `sel2_n`=0. A start strobe with any select inactive performs no access and ends the burst, so any later advance does nothing.
- R8: While `sleep` is high, start strobes, advance and write controls are ignored: no write occurs and the burst state does not change. A read captured before sleep still completes.
- R9: Synchronous active-low reset ends any burst and clears the read pipeline, so `rvalid` is 0 after reset.
- R10: `out_en_n` high forces `rvalid` and `rdata` to zero without waiting for a clock edge, and releasing it restores the pending output at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address for a start strobe |
| wdata | input | DATA_W | Write data |
| sel_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Second chip select, active low |
| proc_start_n | input | 1 | Processor burst start, read only, active low |
| ctrl_start_n | input | 1 | Controller burst start, active low |
| advance_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Enables the per-lane write strobes, active low |
| lane_wr_n | input | DATA_W/8 | Per-lane write strobes, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Power-down, high ignores accesses |
| linear_order | input | 1 | 1 selects linear burst order, 0 interleaved |
| rdata | output | DATA_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid and driven |

## Verification
Two functions can meet at one edge: the output register loading a word for an earlier read, and a write to that same address. The bench provokes this with a processor read of an address, followed in the very next cycle by a controller write to it. The word delivered must be the old one, and a third access to the address must return the new one. A second overlap puts a read's output stage in the same cycle as a sleep request. The read must still be delivered while the write presented during sleep is dropped. A behavioural model, stepped on every edge, judges both cases.

// File: rtl/sram_pkg.sv
// Package: shared types and burst-order helper for the burst SRAM.
// Assumes bursts of four words, stepped by a 2-bit counter.
package sram_pkg;

    typedef enum logic {
        ORDER_INTERLEAVE = 1'b0,
        ORDER_LINEAR     = 1'b1
    } burst_order_e;

    localparam int BURST_BITS = 2;

    // Low address bits of burst word 'step', given the base's low bits.
    function automatic logic [BURST_BITS-1:0] burst_low(
        input logic [BURST_BITS-1:0] base_lo,
        input logic [BURST_BITS-1:0] step,
        input burst_order_e          order
    );
        if (order == ORDER_LINEAR)
            return base_lo + step;
        else
            return base_lo ^ step;
    endfunction

endpackage

// File: rtl/sram_lane_mask.sv
// Module: turns global and per-lane write inputs into a write lane mask.
// Assumes active-low inputs; a zero mask means the access is a read.
module sram_lane_mask #(
    parameter int LANES = 8
) (
    input  logic             all_wr_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] mask
);

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Lane selected by the global write, or by its own strobe when enabled.
            assign mask[g] = ~all_wr_n | (~lane_wr_en_n & ~lane_wr_n[g]);
        end
    endgenerate

endmodule

// File: rtl/sram_burst_seq.sv
// Module: burst start/advance decoder and burst address generator.
// Assumes starts win over advance and the processor start over the
// controller start; sleep blocks all activity and holds burst state.
module sram_burst_seq
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              chip_ok,
    input  logic              proc_start_n,
    input  logic              ctrl_start_n,
    input  logic              advance_n,
    input  logic              sleep,
    input  burst_order_e      order,
    output logic              acc_en,
    output logic              acc_read_only,
    output logic [ADDR_W-1:0] acc_addr
);

    logic                  active_q;
    logic [ADDR_W-1:0]     base_q;
    logic [BURST_BITS-1:0] cnt_q;
    logic [BURST_BITS-1:0] step_d;
    logic                  strobe;
    logic                  start;
    logic                  advance;

    // Decode which kind of access, if any, this cycle presents.
    always_comb begin
        strobe        = ~sleep & (~proc_start_n | ~ctrl_start_n);
        start         = strobe & chip_ok;
        advance       = ~sleep & proc_start_n & ctrl_start_n & ~advance_n & active_q;
        step_d        = cnt_q + 1'b1;
        acc_en        = start | advance;
        acc_read_only = start & ~proc_start_n;
        if (start)
            acc_addr = addr;
        else
            acc_addr = {base_q[ADDR_W-1:BURST_BITS],
                        burst_low(base_q[BURST_BITS-1:0], step_d, order)};
    end

    // Burst state: load on start, clear on deselect, count on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            base_q   <= addr;
            cnt_q    <= '0;
        end else if (strobe) begin
            active_q <= 1'b0;
        end else if (advance) begin
            cnt_q    <= step_d;
        end
    end

    // R7: a start strobe seen with a chip select inactive ends the burst.
    p_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && (!proc_start_n || !ctrl_start_n) && !chip_ok) |=> !active_q);

    // R8: sleep leaves the burst state untouched.
    p_sleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(active_q) && $stable(cnt_q) && $stable(base_q)));

    // R6: each advance moves the counter by exactly one.
    p_adv_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && proc_start_n && ctrl_start_n && !advance_n && active_q)
        |=> (cnt_q == $past(cnt_q) + 2'd1));

endmodule

// File: rtl/sram_array.sv
// Module: lane-split storage with a registered address stage and a
// registered output. Assumes writes and reads never target the same
// access slot; a write lands at the capture edge.
module sram_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W/8-1:0] wr_mask,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] data_q,
    output logic              valid_q
);

    localparam int LANES = DATA_W / 8;
    localparam int DEPTH = 1 << ADDR_W;

    logic              rd_pend_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [DATA_W-1:0] rd_word;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [7:0] lane_mem [DEPTH];

            // Commit this lane's byte when it is selected in the write mask.
            always_ff @(posedge clk) begin
                if (wr_en && wr_mask[g])
                    lane_mem[wr_addr] <= wr_data[8*g +: 8];
            end

            assign rd_word[8*g +: 8] = lane_mem[rd_addr_q];
        end
    endgenerate

    // Address stage: hold the captured read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            rd_pend_q <= rd_en;
            rd_addr_q <= rd_addr;
        end
    end

    // Output stage: load the word one edge after the address stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= rd_pend_q;
            if (rd_pend_q)
                data_q <= rd_word;
        end
    end

    // R1: a captured read reaches the output register two edges later.
    p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ##1 valid_q);

endmodule

// File: rtl/burst_sram.sv
// Module: top of the pipelined synchronous burst SRAM.
// Assumes DATA_W is a multiple of 8; out_en_n acts without a clock.
module burst_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                sel_n,
    input  logic                sel_hi,
    input  logic                sel2_n,
    input  logic                proc_start_n,
    input  logic                ctrl_start_n,
    input  logic                advance_n,
    input  logic                all_wr_n,
    input  logic                lane_wr_en_n,
    input  logic [DATA_W/8-1:0] lane_wr_n,
    input  logic                out_en_n,
    input  logic                sleep,
    input  logic                linear_order,
    output logic [DATA_W-1:0]   rdata,
    output logic                rvalid
);

    localparam int LANES = DATA_W / 8;

    logic              chip_ok;
    logic              acc_en;
    logic              acc_read_only;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  mask;
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    burst_order_e      order;

    // All three selects must be active for a start to count.
    always_comb begin
        chip_ok = ~sel_n & sel_hi & ~sel2_n;
        order   = burst_order_e'(linear_order);
    end

    sram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr          (addr),
        .chip_ok       (chip_ok),
        .proc_start_n  (proc_start_n),
        .ctrl_start_n  (ctrl_start_n),
        .advance_n     (advance_n),
        .sleep         (sleep),
        .order         (order),
        .acc_en        (acc_en),
        .acc_read_only (acc_read_only),
        .acc_addr      (acc_addr)
    );

    sram_lane_mask #(.LANES(LANES)) u_mask (
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_wr_n    (lane_wr_n),
        .mask         (mask)
    );

    // Split the access into a write (any lane selected) or a read.
    always_comb begin
        wr_en = acc_en & ~acc_read_only & (|mask);
        rd_en = acc_en & ~wr_en;
    end

    sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_mask (mask),
        .wr_addr (acc_addr),
        .wr_data (wdata),
        .rd_en   (rd_en),
        .rd_addr (acc_addr),
        .data_q  (data_q),
        .valid_q (valid_q)
    );

    // Output gating by the asynchronous output enable.
    always_comb begin
        rvalid = valid_q & ~out_en_n;
        rdata  = rvalid ? data_q : '0;
    end

    // R8: no access of any kind leaves the decoder while sleeping.
    p_sleep_noacc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !(wr_en || rd_en));

    // R5: a processor start never writes.
    p_proc_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_start_n && !sleep) |-> !wr_en);

    // R3: a global write selects every lane.
    p_global_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !all_wr_n |-> (mask == {LANES{1'b1}}));

endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;
    localparam int AW = 8;
    localparam int DW = 64;
    localparam int NL = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          sel_n = 1'b0, sel_hi = 1'b1, sel2_n = 1'b0;
    logic          proc_start_n = 1'b1, ctrl_start_n = 1'b1, advance_n = 1'b1;
    logic          all_wr_n = 1'b1, lane_wr_en_n = 1'b1;
    logic [NL-1:0] lane_wr_n = '1;
    logic          out_en_n = 1'b0, sleep = 1'b0, linear_order = 1'b1;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int    checks = 0;
    int    failures = 0;
    string tag = "R9";

    // Reference model state
    logic [DW-1:0] mmem [DEPTH];
    bit            m_act = 0;
    int            m_base = 0;
    int            m_cnt = 0;
    bit            p1_v = 0;
    int            p1_a = 0;
    bit            o_v = 0;
    logic [DW-1:0] o_d = '0;

    always #10 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
        .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n),
        .advance_n(advance_n), .all_wr_n(all_wr_n),
        .lane_wr_en_n(lane_wr_en_n), .lane_wr_n(lane_wr_n),
        .out_en_n(out_en_n), .sleep(sleep), .linear_order(linear_order),
        .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [DW-1:0] pat(int a);
        return (64'h0123_4567_89AB_CDEF * 64'(a + 3)) ^ 64'(a);
    endfunction

    task automatic chk(string t, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h at %0t", t, got, exp, $time);
        end
    endtask

    // Model one rising edge from the inputs the bench drove.
    task automatic model_edge();
        bit acc = 0, wr_ok = 0;
        int a = 0, lo;
        logic [NL-1:0] msk;
        if (!rst_n) begin
            m_act = 0; m_cnt = 0; p1_v = 0; o_v = 0;
            return;
        end
        o_v = p1_v;
        if (p1_v) o_d = mmem[p1_a];
        if (!sleep) begin
            if (!proc_start_n || !ctrl_start_n) begin
                if (!sel_n && sel_hi && !sel2_n) begin
                    m_act = 1; m_base = int'(addr); m_cnt = 0;
                    acc = 1; wr_ok = proc_start_n; a = int'(addr);
                end else m_act = 0;
            end else if (!advance_n && m_act) begin
                m_cnt = (m_cnt + 1) % 4;
                lo = linear_order ? ((m_base + m_cnt) % 4) : ((m_base % 4) ^ m_cnt);
                a = (m_base / 4) * 4 + lo;
                acc = 1; wr_ok = 1;
            end
        end
        for (int i = 0; i < NL; i++)
            msk[i] = !all_wr_n || (!lane_wr_en_n && !lane_wr_n[i]);
        p1_v = 0;
        if (acc && wr_ok && msk != 0) begin
            for (int i = 0; i < NL; i++)
                if (msk[i]) mmem[a][8*i +: 8] = wdata[8*i +: 8];
        end else if (acc) begin
            p1_v = 1; p1_a = a;
        end
    endtask

    task automatic step();
        logic          ev;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        ev = o_v && !out_en_n;
        chk({tag, " rvalid"}, 64'(rvalid), 64'(ev));
        chk({tag, " rdata"}, rdata, ev ? o_d : '0);
    endtask

    task automatic idle();
        proc_start_n = 1; ctrl_start_n = 1; advance_n = 1;
        all_wr_n = 1; lane_wr_en_n = 1; lane_wr_n = '1;
        sleep = 0; out_en_n = 0; sel_n = 0; sel_hi = 1; sel2_n = 0;
    endtask

    task automatic nop(); idle(); step(); endtask
    task automatic rd(int a); idle(); proc_start_n = 0; addr = AW'(a); step(); endtask
    task automatic wr(int a, logic [DW-1:0] d);
        idle(); ctrl_start_n = 0; all_wr_n = 0; addr = AW'(a); wdata = d; step();
    endtask
    task automatic adv(); idle(); advance_n = 0; step(); endtask

    initial begin
        #(20 * 150000);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R9: reset state
        idle();
        repeat (3) step();
        chk("R9 reset rvalid", 64'(rvalid), 64'(0));
        rst_n = 1;
        nop();

        // R5 R6: fill memory with controller-started linear write bursts
        tag = "R5 fill";
        linear_order = 1;
        for (int b = 0; b < DEPTH; b += 4) begin
            wr(b, pat(b));
            for (int k = 1; k < 4; k++) begin
                idle(); advance_n = 0; all_wr_n = 0; wdata = pat(b + k); step();
            end
        end
        nop();

        // R1 R6: linear read burst from an unaligned base, with wrap
        tag = "R6 linear";
        rd(5);
        repeat (7) adv();
        nop(); nop();
        tag = "R6 interleave";
        linear_order = 0;
        rd(6);
        repeat (3) adv();
        nop(); nop();
        linear_order = 1;
        tag = "R1 latency";
        rd(9); nop();
        chk("R1 data after second edge", rdata, pat(9));
        nop();

        // R2: lane writes, and lane strobes ignored without the enable
        tag = "R2 lanes";
        idle(); ctrl_start_n = 0; lane_wr_en_n = 0; lane_wr_n = 8'b1010_0101;
        addr = 10; wdata = 64'hFFEE_DDCC_BBAA_9988; step();
        rd(10); nop(); nop();
        idle(); ctrl_start_n = 0; lane_wr_en_n = 1; lane_wr_n = '0;
        addr = 11; wdata = '0; step();
        nop(); nop();
        rd(11); nop(); nop();

        // R3: global write overrides lane controls
        tag = "R3 global";
        idle(); ctrl_start_n = 0; all_wr_n = 0; lane_wr_en_n = 0; lane_wr_n = '1;
        addr = 12; wdata = 64'h1111_2222_3333_4444; step();
        rd(12); nop(); nop();

        // R4: write then read next cycle; read output stage meets a write
        tag = "R4 overlap";
        wr(20, 64'hA5A5_0000_5A5A_FFFF);
        rd(20); nop(); nop();
        rd(30);
        wr(30, 64'hDEAD_BEEF_0BAD_F00D);
        nop();
        rd(30); nop(); nop();

        // R5: processor start ignores write controls and wins over controller
        tag = "R5 proc";
        idle(); proc_start_n = 0; all_wr_n = 0; addr = 40; wdata = '0; step();
        nop(); nop();
        idle(); proc_start_n = 0; ctrl_start_n = 0; all_wr_n = 0; addr = 41; wdata = '0; step();
        nop(); nop();
        rd(40); nop(); nop();
        rd(41); nop(); nop();

        // R7: inactive select blocks the start and ends the burst
        tag = "R7 select";
        rd(44);
        idle(); ctrl_start_n = 0; all_wr_n = 0; sel_hi = 0; addr = 50; wdata = '0; step();
        idle(); advance_n = 0; all_wr_n = 0; wdata = '0; step();
        idle(); ctrl_start_n = 0; all_wr_n = 0; sel2_n = 1; addr = 51; wdata = '0; step();
        nop(); nop();
        rd(50); nop(); nop();
        rd(51); nop(); nop();
        rd(44); nop(); nop();

        // R8: sleep ignores accesses, earlier read still delivered
        tag = "R8 sleep";
        rd(60);
        idle(); sleep = 1; ctrl_start_n = 0; all_wr_n = 0; addr = 60; wdata = '0; step();
        idle(); sleep = 1; advance_n = 0; all_wr_n = 0; wdata = '0; step();
        nop();
        rd(60); nop(); nop();
        rd(61); nop(); nop();

        // R10: output enable acts without a clock edge
        tag = "R10 oe";
        rd(70); nop();
        out_en_n = 1; #1;
        chk("R10 rvalid gated", 64'(rvalid), 64'(0));
        chk("R10 rdata gated", rdata, '0);
        out_en_n = 0; #1;
        chk("R10 rvalid restored", 64'(rvalid), 64'(1));
        chk("R10 rdata restored", rdata, pat(70));
        nop();
        rd(71);
        idle(); out_en_n = 1; step();
        nop();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule